// File: doc/BRIEF.md
# SIMT Divergence Mask Controller

This block tracks which of the 32 lanes of a warp may commit results while the warp runs under a single shared instruction pointer. Every lane still steps through every instruction. The controller's only product is a per-lane write-enable vector. When a 0 sits in lane i's bit, lane i's register write is dropped for that instruction, and the lane still uses its slot.

The fetch side sends commands. On a branch it sends a 32-bit condition vector and the address of the not-taken code. The controller first runs the taken path under the lanes that are both active and have their condition bit set. A switch command then moves the warp onto the not-taken path, under the remaining active lanes. A reconverge command restores the mask that held before the branch.

A small stack of saved contexts allows branches to nest. A phase output and a one-cycle PC-select pulse tell the fetch side which path is running and when to jump to the saved not-taken address. The command port is a plain strobe with no back-pressure: a command is taken in every cycle that `cmd_valid_i` is high.

Top module: `simt_mask_ctrl`

## Requirements
- R1: After reset, `lane_we_o` is all ones, `phase_o` is 0 (idle), and `pc_sel_o`, `else_pc_o` and `overflow_o` are 0.
- R2: Outputs are registered. They change only in the cycle after an accepted command (`cmd_valid_i`=1, with `cmd_op_i` 1=branch, 2=switch, 3=reconverge, 0=no-op). Bit i of `lane_we_o` is lane i's write-enable: 1 keeps the lane's result and 0 drops it.
- R3: A branch whose taken set (current mask AND condition) is non-zero has these effects. `lane_we_o` becomes the taken set, `phase_o` becomes 1 (taken), `pc_sel_o` stays 0, and `else_pc_o` takes the supplied not-taken address.
- R4: A branch whose taken set is empty skips the taken phase. `lane_we_o` becomes current mask AND NOT condition, `phase_o` becomes 2 (else), and `pc_sel_o` pulses.
- R5: A switch in the taken phase whose saved else set is non-zero has these effects. `lane_we_o` becomes the pre-branch mask AND NOT condition, `phase_o` becomes 2, and `pc_sel_o` pulses. Lanes that were inactive before the branch stay inactive.
- R6: A switch changes nothing in any of three cases: the active lanes were uniform (the else set is empty), the phase is already else, or no branch is open. In each case the warp runs only one path.
- R7: A reconverge restores the mask saved by the matching branch. `phase_o` and `else_pc_o` return to the enclosing branch's values, or to 0 and 0 when no branch remains open. A reconverge with no open branch changes nothing.
- R8: Up to 4 branches nest. A branch arriving while 4 are open leaves the mask, the phase and the address unchanged. It sets `overflow_o`, which stays high until reset.
- R9: `pc_sel_o` is high only in the single cycle after the command that entered the else phase, and only while `phase_o` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 no-op, 1 branch, 2 switch, 3 reconverge |
| cond_i | input | 32 | Per-lane branch condition (used by branch) |
| else_pc_i | input | 16 | Not-taken path address (used by branch) |
| lane_we_o | output | 32 | Per-lane register write-enable |
| phase_o | output | 2 | 0 idle, 1 taken path, 2 else path |
| pc_sel_o | output | 1 | One-cycle request to fetch from `else_pc_o` |
| else_pc_o | output | 16 | Not-taken address of the innermost open branch |
| overflow_o | output | 1 | Sticky flag: a branch arrived with the stack full |

## Verification
Condition vectors are swept as single set bits, single cleared bits, all zeros, all ones and pseudo-random words.

- A single set bit against a full mask separates the taken set from its complement.
- All zeros and all ones exercise the two uniform cases, where one phase must vanish.
- The same patterns are also applied inside an outer branch. This shows that lanes masked before the branch stay masked in both inner phases and come back intact at reconvergence.

Nesting to the stack limit, then one branch beyond it, exposes the overflow and the ignore behaviour. A reconverge with no open branch checks that an unmatched pop is harmless.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    CMD_NOP    = 2'd0,
    CMD_BRANCH = 2'd1,
    CMD_SWITCH = 2'd2,
    CMD_RECONV = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TAKEN = 2'd1,
    PH_ELSE  = 2'd2
  } phase_e;
endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] active_i,
  input  logic [LANES-1:0] cond_i,
  output logic [LANES-1:0] taken_o,
  output logic [LANES-1:0] alt_o,
  output logic             taken_none_o
);
  // Lanes already off stay off on both sides of the branch.
  assign taken_o      = active_i & cond_i;
  assign alt_o        = active_i & ~cond_i;
  assign taken_none_o = (taken_o == '0);
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             mark_i,
  input  logic [LANES-1:0] push_saved_i,
  input  logic [LANES-1:0] push_alt_i,
  input  logic [PC_W-1:0]  push_pc_i,
  input  logic             push_inalt_i,
  output logic             empty_o,
  output logic             full_o,
  output logic [LANES-1:0] top_saved_o,
  output logic [LANES-1:0] top_alt_o,
  output logic             top_inalt_o,
  output logic             below_valid_o,
  output logic             below_inalt_o,
  output logic [PC_W-1:0]  below_pc_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    cnt_q;
  logic [LANES-1:0] saved_q [DEPTH];
  logic [LANES-1:0] alt_q   [DEPTH];
  logic [PC_W-1:0]  pc_q    [DEPTH];
  logic             inalt_q [DEPTH];

  assign empty_o       = (cnt_q == '0);
  assign full_o        = (cnt_q == CW'(DEPTH));
  assign below_valid_o = (cnt_q > CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + CW'(1);
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - CW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        saved_q[g] <= '0;
        alt_q[g]   <= '0;
        pc_q[g]    <= '0;
        inalt_q[g] <= 1'b0;
      end else if (push_i && !full_o && cnt_q == CW'(g)) begin
        saved_q[g] <= push_saved_i;
        alt_q[g]   <= push_alt_i;
        pc_q[g]    <= push_pc_i;
        inalt_q[g] <= push_inalt_i;
      end else if (mark_i && cnt_q == CW'(g + 1)) begin
        inalt_q[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    top_saved_o   = '0;
    top_alt_o     = '0;
    top_inalt_o   = 1'b0;
    below_inalt_o = 1'b0;
    below_pc_o    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) begin
        top_saved_o = saved_q[i];
        top_alt_o   = alt_q[i];
        top_inalt_o = inalt_q[i];
      end
      if (cnt_q == CW'(i + 2)) begin
        below_inalt_o = inalt_q[i];
        below_pc_o    = pc_q[i];
      end
    end
  end

  // R8
  stk_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R7
  stk_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PC_W  = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [LANES-1:0] cond_i,
  input  logic [PC_W-1:0]  else_pc_i,
  output logic [LANES-1:0] lane_we_o,
  output logic [1:0]       phase_o,
  output logic             pc_sel_o,
  output logic [PC_W-1:0]  else_pc_o,
  output logic             overflow_o
);
  logic [LANES-1:0] mask_q;
  phase_e           phase_q;
  logic             psel_q, ovf_q;
  logic [PC_W-1:0]  apc_q;

  logic [LANES-1:0] taken, alt, top_saved, top_alt;
  logic             taken_none, empty, full, top_inalt;
  logic             below_valid, below_inalt;
  logic [PC_W-1:0]  below_pc;

  cmd_e op;
  logic is_br, is_sw, is_rc, do_push, do_pop, do_sw;

  assign op      = cmd_e'(cmd_op_i);
  assign is_br   = cmd_valid_i && op == CMD_BRANCH;
  assign is_sw   = cmd_valid_i && op == CMD_SWITCH;
  assign is_rc   = cmd_valid_i && op == CMD_RECONV;
  assign do_push = is_br && !full;
  assign do_pop  = is_rc && !empty;
  assign do_sw   = is_sw && !empty && !top_inalt && top_alt != '0;

  simt_branch_split #(.LANES(LANES)) u_split (
    .active_i     (mask_q),
    .cond_i       (cond_i),
    .taken_o      (taken),
    .alt_o        (alt),
    .taken_none_o (taken_none)
  );

  simt_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (do_push),
    .pop_i         (do_pop),
    .mark_i        (do_sw),
    .push_saved_i  (mask_q),
    .push_alt_i    (alt),
    .push_pc_i     (else_pc_i),
    .push_inalt_i  (taken_none),
    .empty_o       (empty),
    .full_o        (full),
    .top_saved_o   (top_saved),
    .top_alt_o     (top_alt),
    .top_inalt_o   (top_inalt),
    .below_valid_o (below_valid),
    .below_inalt_o (below_inalt),
    .below_pc_o    (below_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      phase_q <= PH_IDLE;
      psel_q  <= 1'b0;
      apc_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      psel_q <= 1'b0;
      if (is_br && full) ovf_q <= 1'b1;
      if (do_push) begin
        mask_q  <= taken_none ? alt : taken;
        phase_q <= taken_none ? PH_ELSE : PH_TAKEN;
        psel_q  <= taken_none;
        apc_q   <= else_pc_i;
      end else if (do_sw) begin
        mask_q  <= top_alt;
        phase_q <= PH_ELSE;
        psel_q  <= 1'b1;
      end else if (do_pop) begin
        mask_q  <= top_saved;
        phase_q <= !below_valid ? PH_IDLE : (below_inalt ? PH_ELSE : PH_TAKEN);
        apc_q   <= below_valid ? below_pc : '0;
      end
    end
  end

  assign lane_we_o  = mask_q;
  assign phase_o    = phase_q;
  assign pc_sel_o   = psel_q;
  assign else_pc_o  = apc_q;
  assign overflow_o = ovf_q;

  // R3
  taken_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (lane_we_o & ~$past(lane_we_o)) == '0);
  // R7
  restore_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> lane_we_o == $past(top_saved));
  // R7
  idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (phase_o == PH_IDLE));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  // R9
  psel_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_o |-> phase_o == PH_ELSE);
endmodule

// File: tb/sim_simt_mask_ctrl.sv
module sim_simt_mask_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'd0;
  logic [31:0] cond_i = '0;
  logic [15:0] else_pc_i = '0;
  logic [31:0] lane_we_o;
  logic [1:0]  phase_o;
  logic        pc_sel_o;
  logic [15:0] else_pc_o;
  logic        overflow_o;

  int total = 0;
  int bad = 0;

  logic [31:0] m_saved [DEPTH];
  logic [31:0] m_alt   [DEPTH];
  logic [15:0] m_pc    [DEPTH];
  logic        m_inalt [DEPTH];
  int          m_cnt = 0;
  logic [31:0] m_mask = '1;
  logic [1:0]  m_phase = 2'd0;
  logic        m_psel = 1'b0;
  logic [15:0] m_apc = '0;
  logic        m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_mask_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cond_i(cond_i), .else_pc_i(else_pc_i), .lane_we_o(lane_we_o),
    .phase_o(phase_o), .pc_sel_o(pc_sel_o), .else_pc_o(else_pc_o),
    .overflow_o(overflow_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "lane_we", lane_we_o, m_mask);
    chk(tag, "phase", {30'd0, phase_o}, {30'd0, m_phase});
    chk(tag, "pc_sel", {31'd0, pc_sel_o}, {31'd0, m_psel});
    chk(tag, "else_pc", {16'd0, else_pc_o}, {16'd0, m_apc});
    chk(tag, "overflow", {31'd0, overflow_o}, {31'd0, m_ovf});
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] c, input logic [15:0] pc);
    string tag;
    logic [31:0] tk, al;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cond_i = c; else_pc_i = pc;
    m_psel = 1'b0;
    tag = "R2";
    if (op == 2'd1) begin
      if (m_cnt == DEPTH) begin
        m_ovf = 1'b1; tag = "R8";
      end else begin
        tk = m_mask & c; al = m_mask & ~c;
        m_saved[m_cnt] = m_mask; m_alt[m_cnt] = al;
        m_inalt[m_cnt] = (tk == 0); m_pc[m_cnt] = pc;
        m_cnt++;
        m_apc = pc;
        if (tk != 0) begin m_mask = tk; m_phase = 2'd1; tag = "R3"; end
        else begin m_mask = al; m_phase = 2'd2; m_psel = 1'b1; tag = "R4"; end
      end
    end else if (op == 2'd2) begin
      if (m_cnt != 0 && !m_inalt[m_cnt-1] && m_alt[m_cnt-1] != 0) begin
        m_inalt[m_cnt-1] = 1'b1; m_mask = m_alt[m_cnt-1];
        m_phase = 2'd2; m_psel = 1'b1; tag = "R5";
      end else tag = "R6";
    end else if (op == 2'd3) begin
      tag = "R7";
      if (m_cnt != 0) begin
        m_mask = m_saved[m_cnt-1];
        m_cnt--;
        if (m_cnt == 0) begin m_phase = 2'd0; m_apc = '0; end
        else begin
          m_phase = m_inalt[m_cnt-1] ? 2'd2 : 2'd1;
          m_apc = m_pc[m_cnt-1];
        end
      end
    end
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = 2'd0;
    check_all(tag);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    m_psel = 1'b0;
    check_all("R9");
  endtask

  function automatic logic [31:0] pat(input int k);
    if (k < 32) return 32'd1 << k;
    else if (k < 64) return ~(32'd1 << (k - 32));
    else if (k == 64) return 32'd0;
    else if (k == 65) return 32'hFFFF_FFFF;
    else return 32'(k * 32'h9E37_79B9 + 32'h1234_5677);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: a non-accepted cycle and a no-op leave outputs alone
    @(negedge clk);
    cond_i = 32'h0; cmd_op_i = 2'd1; cmd_valid_i = 1'b0;
    @(negedge clk);
    cmd_op_i = 2'd0;
    check_all("R2");
    issue(2'd0, 32'hFFFF, 16'h5);

    // R7: reconverge with nothing open is ignored; R6: switch likewise
    issue(2'd3, '0, '0);
    issue(2'd2, '0, '0);

    // Single-level sweep: R3 R4 R5 R6 R7 R9
    for (int k = 0; k < 100; k++) begin
      issue(2'd1, pat(k), 16'(k + 16'h100));
      idle_cycle();
      issue(2'd2, '0, '0);
      issue(2'd2, '0, '0);
      issue(2'd3, '0, '0);
    end

    // Two-level sweep: inner branch under a partial mask
    for (int k = 0; k < 100; k++) begin
      issue(2'd1, pat(k + 13), 16'(k + 16'h200));
      issue(2'd1, pat(k), 16'(k + 16'h300));
      issue(2'd2, '0, '0);
      issue(2'd3, '0, '0);
      issue(2'd2, '0, '0);
      issue(2'd3, '0, '0);
    end

    // R8: nest to the limit, then one more
    issue(2'd1, 32'hFFFF_0000, 16'h11);
    issue(2'd1, 32'hFF00_FF00, 16'h22);
    issue(2'd2, '0, '0);
    issue(2'd1, 32'hF0F0_F0F0, 16'h33);
    issue(2'd1, 32'hCCCC_CCCC, 16'h44);
    issue(2'd1, 32'hAAAA_AAAA, 16'h55);
    issue(2'd1, 32'h0000_0000, 16'h66);
    for (int d = 0; d < DEPTH + 1; d++) issue(2'd3, '0, '0);
    idle_cycle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule